// File: doc/BRIEF.md
# Programmable Timer Time Base with Double-Buffered Period

This block is the counting core of a 16-bit timer. An input clock, gated by a per-cycle count-clock enable, passes through a programmable divider to make count ticks. A counter steps on each tick in one of three shapes: rising with a wrap to zero, falling with a reload from the period value, or rising and then falling like a triangle. Each wrap can produce an update event. A repetition value can suppress a set number of wraps between updates.

The divider value, and the period value when its buffering bit is set, are written into holding registers. They reach the working (shadow) copies only on an update event, so a period never changes halfway through. Software can force an update to load new settings at once. Each update raises a sticky flag that software clears. The flag raises an interrupt line only when its enable is set. A single-cycle pulse marks each update for neighbouring logic.

Top module: `tbu_timebase`

## Requirements
- R1: After reset the counter reads 0, the flag, interrupt and update pulse are low, the divider reads 0, the period reads 0xFFFF and the repetition reads 0. Registers sit at addr 0 control (bit0 run, bit1 count down, bit2 triangle mode which overrides bit1, bit3 period buffering), 1 interrupt enable (bit0), 2 status (bit0 flag), 3 event (bit0 forces update), 4 counter, 5 divider, 6 period, 7 repetition. Reads of 5 and 6 return the written value.
- R2: With run set and the count-clock enable high, one count tick occurs every DIV+1 input clocks.
- R3: A divider write takes effect only at the update event that follows it. The period that is running when the write arrives finishes with the old divider.
- R4: In up mode the counter climbs from 0 to PERIOD, and the next tick returns it to 0 with an update, giving (DIV+1)*(PERIOD+1) clocks between updates.
- R5: With period buffering set, a period write applies from the next update. With buffering clear it applies at once, and a value below the current count makes the counter run on to 0xFFFF before it wraps and updates.
- R6: Each update sets the flag. The flag holds until a status write with bit0 at 0, and a write with bit0 at 1 leaves it set. The interrupt line is high only while the flag and the enable are both set.
- R7: Writing 1 to event bit0 forces an update in the same step. It loads the held divider, period and repetition into the working copies, clears the divider phase, sets the counter to 0 (to PERIOD in down mode), and sets the flag.
- R8: In down mode the counter falls to 0, and the next tick reloads it to PERIOD with an update, giving (DIV+1)*(PERIOD+1) clocks between updates.
- R9: In triangle mode the counter rises from 0 to PERIOD and falls back to 0. An update occurs at both turning points, (DIV+1)*PERIOD clocks apart.
- R10: With repetition value N, only every (N+1)th wrap produces an update. N=0 gives an update on every wrap.
- R11: While run is clear or the count-clock enable is low, the divider phase and the counter hold their values.
- R12: The update pulse is high for exactly one cycle for each update. It is the first cycle in which the new working values apply and the flag reads set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Count-clock enable, qualifies each input clock |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data for addr |
| upd_pulse | output | 1 | One-cycle update event marker |
| upd_flag | output | 1 | Sticky update flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is an unbuffered period write that lands below the live count. The bench waits a fixed number of clocks after an update so the counter sits clearly above the new value, and only then writes the period. It then checks that the next update arrives after the full 16-bit wrap, and that the update after that uses the short period. The divider and period handover is reached the same way. The new value is written just after an update, and the bench checks that the period in progress keeps the old value while the period after it uses the new one.

// File: rtl/tbu_pkg.sv
package tbu_pkg;

  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_IEN  = 3'd1,
    A_STAT = 3'd2,
    A_EVG  = 3'd3,
    A_CNT  = 3'd4,
    A_PSC  = 3'd5,
    A_ARR  = 3'd6,
    A_REP  = 3'd7
  } reg_addr_e;

  localparam int CTL_RUN  = 0;
  localparam int CTL_DOWN = 1;
  localparam int CTL_TRI  = 2;
  localparam int CTL_BUF  = 3;

  typedef enum logic [1:0] {
    MODE_UP   = 2'd0,
    MODE_DOWN = 2'd1,
    MODE_TRI  = 2'd2
  } cnt_mode_e;

  function automatic cnt_mode_e decode_mode(input logic tri_bit, input logic down_bit);
    if (tri_bit)       return MODE_TRI;
    else if (down_bit) return MODE_DOWN;
    else               return MODE_UP;
  endfunction

endpackage

// File: rtl/tbu_prescaler.sv
module tbu_prescaler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         clr,
  input  logic [W-1:0] lim,
  output logic         tick,
  output logic [W-1:0] phase
);

  assign tick = step && (phase == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     phase <= '0;
    else if (clr)   phase <= '0;
    else if (step)  phase <= tick ? '0 : phase + 1'b1;
  end

endmodule

// File: rtl/tbu_counter.sv
module tbu_counter
  import tbu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  cnt_mode_e    mode,
  input  logic [W-1:0] top_val,
  input  logic [W-1:0] reload_val,
  input  logic         force_ld,
  input  logic [W-1:0] force_val,
  input  logic         sw_ld,
  input  logic [W-1:0] sw_val,
  output logic [W-1:0] cnt,
  output logic         wrap
);

  logic         falling_q, falling_n;
  logic [W-1:0] cnt_n;
  localparam logic [W-1:0] CNT_MAX = '1;

  always_comb begin
    cnt_n     = cnt;
    falling_n = falling_q;
    wrap      = 1'b0;
    if (tick) begin
      unique case (mode)
        MODE_DOWN: begin
          if (cnt == '0) begin wrap = 1'b1; cnt_n = reload_val; end
          else cnt_n = cnt - 1'b1;
        end
        MODE_TRI: begin
          if (!falling_q) begin
            if (cnt >= top_val) begin
              wrap      = 1'b1;
              cnt_n     = (cnt == '0) ? '0 : cnt - 1'b1;
              falling_n = (cnt != '0);
            end else cnt_n = cnt + 1'b1;
          end else begin
            if (cnt == '0) begin
              wrap      = 1'b1;
              cnt_n     = (top_val == '0) ? '0 : {{(W-1){1'b0}}, 1'b1};
              falling_n = 1'b0;
            end else cnt_n = cnt - 1'b1;
          end
        end
        default: begin
          if (cnt == top_val || cnt == CNT_MAX) begin wrap = 1'b1; cnt_n = '0; end
          else cnt_n = cnt + 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      falling_q <= 1'b0;
    end else if (force_ld) begin
      cnt       <= force_val;
      falling_q <= 1'b0;
    end else if (sw_ld) begin
      cnt       <= sw_val;
    end else begin
      cnt       <= cnt_n;
      falling_q <= falling_n;
    end
  end

endmodule

// File: rtl/tbu_repeat.sv
module tbu_repeat #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wrap,
  input  logic         force_ld,
  input  logic [W-1:0] rep_val,
  output logic         rep_zero,
  output logic         nat_upd
);

  logic [W-1:0] left_q;

  assign rep_zero = (left_q == '0);
  assign nat_upd  = wrap && rep_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   left_q <= '0;
    else if (force_ld || nat_upd) left_q <= rep_val;
    else if (wrap)                left_q <= left_q - 1'b1;
  end

endmodule

// File: rtl/tbu_timebase.sv
module tbu_timebase
  import tbu_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              upd_pulse,
  output logic              upd_flag,
  output logic              irq
);

  localparam logic [CNT_W-1:0] ARR_RST = '1;

  logic             run_q, down_q, tri_q, buf_q, ien_q;
  logic [CNT_W-1:0] psc_pre, psc_act, arr_pre, arr_act, rep_pre;
  logic [CNT_W-1:0] pcnt, cnt_q, reload_val, force_val;
  logic             step, cnt_tick, wrap, rep_zero, nat_upd;
  logic             force_upd, upd_evt;
  logic             wr_ctrl, wr_ien, wr_stat, wr_cnt, wr_psc, wr_arr, wr_rep;
  cnt_mode_e        mode;

  assign wr_ctrl   = wr_en && (addr == A_CTRL);
  assign wr_ien    = wr_en && (addr == A_IEN);
  assign wr_stat   = wr_en && (addr == A_STAT);
  assign wr_cnt    = wr_en && (addr == A_CNT);
  assign wr_psc    = wr_en && (addr == A_PSC);
  assign wr_arr    = wr_en && (addr == A_ARR);
  assign wr_rep    = wr_en && (addr == A_REP);
  assign force_upd = wr_en && (addr == A_EVG) && wdata[0];

  assign mode       = decode_mode(tri_q, down_q);
  assign step       = run_q && tick_en;
  assign upd_evt    = force_upd || nat_upd;
  assign reload_val = rep_zero ? arr_pre : arr_act;
  assign force_val  = (mode == MODE_DOWN) ? arr_pre : '0;

  tbu_prescaler #(.W(CNT_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .step(step), .clr(force_upd),
    .lim(psc_act), .tick(cnt_tick), .phase(pcnt)
  );

  tbu_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(cnt_tick), .mode(mode),
    .top_val(arr_act), .reload_val(reload_val),
    .force_ld(force_upd), .force_val(force_val),
    .sw_ld(wr_cnt), .sw_val(wdata),
    .cnt(cnt_q), .wrap(wrap)
  );

  tbu_repeat #(.W(CNT_W)) u_rep (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .force_ld(force_upd),
    .rep_val(rep_pre), .rep_zero(rep_zero), .nat_upd(nat_upd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; down_q <= 1'b0; tri_q <= 1'b0; buf_q <= 1'b0;
      ien_q <= 1'b0;
      psc_pre <= '0; psc_act <= '0;
      arr_pre <= ARR_RST; arr_act <= ARR_RST;
      rep_pre <= '0;
      upd_flag <= 1'b0; upd_pulse <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        run_q  <= wdata[CTL_RUN];
        down_q <= wdata[CTL_DOWN];
        tri_q  <= wdata[CTL_TRI];
        buf_q  <= wdata[CTL_BUF];
      end
      if (wr_ien) ien_q   <= wdata[0];
      if (wr_psc) psc_pre <= wdata;
      if (wr_rep) rep_pre <= wdata;
      if (wr_arr) arr_pre <= wdata;
      if (upd_evt) psc_act <= psc_pre;
      if (wr_arr && !buf_q) arr_act <= wdata;
      else if (upd_evt)     arr_act <= arr_pre;
      if (upd_evt)      upd_flag <= 1'b1;
      else if (wr_stat && !wdata[0]) upd_flag <= 1'b0;
      upd_pulse <= upd_evt;
    end
  end

  assign irq = upd_flag && ien_q;

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_CTRL: rdata = CNT_W'({buf_q, tri_q, down_q, run_q});
      A_IEN:  rdata = CNT_W'(ien_q);
      A_STAT: rdata = CNT_W'(upd_flag);
      A_CNT:  rdata = cnt_q;
      A_PSC:  rdata = psc_pre;
      A_ARR:  rdata = arr_pre;
      A_REP:  rdata = rep_pre;
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/tbu_chk.sv
module tbu_chk
  import tbu_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [2:0]   addr,
  input logic [W-1:0] wdata,
  input logic         upd_pulse,
  input logic         upd_flag,
  input logic         irq,
  input logic         run_q,
  input cnt_mode_e    mode,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] arr_act,
  input logic [W-1:0] psc_act,
  input logic [W-1:0] pcnt,
  input logic         upd_evt
);

  // R2
  prescale_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= psc_act);

  // R3
  psc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_evt |=> $stable(psc_act));

  // R4
  up_wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_pulse && mode == MODE_UP && !$past(wr_en)) |-> cnt_q == '0);

  // R8
  down_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_pulse && mode == MODE_DOWN && !$past(wr_en)) |-> cnt_q == arr_act);

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_flag && !(wr_en && addr == A_STAT && !wdata[0])) |=> upd_flag);

  // R6
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> upd_flag);

  // R12
  pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse |-> upd_flag);

  // R11
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_en) |=> $stable(cnt_q));

endmodule

bind tbu_timebase tbu_chk #(.W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .upd_pulse(upd_pulse), .upd_flag(upd_flag), .irq(irq), .run_q(run_q),
  .mode(mode), .cnt_q(cnt_q), .arr_act(arr_act), .psc_act(psc_act),
  .pcnt(pcnt), .upd_evt(upd_evt)
);

// File: tb/tbu_timebase_tb.sv
module tbu_timebase_tb;

  localparam int RUN = 1, DOWN = 2, TRI = 4, BUF = 8;

  logic        clk = 0, rst_n = 0, tick_en = 1, wr_en = 0;
  logic [2:0]  addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic        upd_pulse, upd_flag, irq;
  int          nchk = 0, nfail = 0;
  longint      cyc = 0;

  tbu_timebase u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .upd_pulse(upd_pulse), .upd_flag(upd_flag), .irq(irq)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1; addr = 3'(a); wdata = 16'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input int a, output longint d);
    addr = 3'(a);
    #1 d = rdata;
  endtask

  task automatic wait_pulse(input string req, output longint t);
    t = -1;
    for (int i = 0; i < 100000; i++) begin
      @(negedge clk);
      if (upd_pulse) begin t = cyc; break; end
    end
    if (t < 0) check({req, " pulse timeout"}, 0, 1);
  endtask

  task automatic cfg(input int ctl, input int psc, input int arr, input int rep);
    wr(0, ctl & ~RUN);
    wr(5, psc); wr(6, arr); wr(7, rep);
    wr(3, 1);
    wr(2, 0);
    wr(0, ctl | RUN);
  endtask

  function automatic longint exp_period(input int ctl, input int psc, input int arr, input int rep);
    longint span = ((ctl & TRI) != 0) ? longint'(arr) : longint'(arr) + 1;
    return span * (psc + 1) * (rep + 1);
  endfunction

  task automatic measure(input string req, input int ctl, input int psc, input int arr, input int rep);
    longint t1, t2;
    cfg(ctl, psc, arr, rep);
    wait_pulse(req, t1);
    wait_pulse(req, t2);
    check(req, t2 - t1, exp_period(ctl, psc, arr, rep));
  endtask

  initial begin
    #1_900_000;
    check("watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    longint v, t1, t2, t3;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values
    rd(4, v); check("R1 cnt", v, 0);
    rd(5, v); check("R1 psc", v, 0);
    rd(6, v); check("R1 arr", v, 16'hFFFF);
    rd(7, v); check("R1 rep", v, 0);
    check("R1 flag", upd_flag, 0);
    check("R1 irq", irq, 0);
    check("R1 pulse", upd_pulse, 0);
    wr(0, DOWN | BUF); rd(0, v); check("R1 ctrl readback", v, DOWN | BUF);
    wr(1, 1); rd(1, v); check("R1 ien readback", v, 1);
    wr(1, 0); wr(0, 0);

    // R2 R4 up-mode sweep
    for (int p = 0; p < 4; p++)
      for (int a = 0; a < 5; a++) measure("R2 R4 up period", BUF, p, a, 0);
    // R8 down-mode sweep
    for (int p = 0; p < 3; p++)
      for (int a = 0; a < 4; a++) measure("R8 down period", BUF | DOWN, p, a, 0);
    // R9 triangle sweep
    for (int p = 0; p < 3; p++)
      for (int a = 1; a < 5; a++) measure("R9 triangle half period", BUF | TRI, p, a, 0);
    // R10 repetition sweep
    for (int r = 0; r < 4; r++) measure("R10 repetition period", BUF, 1, 2, r);
    measure("R10 repetition triangle", BUF | TRI, 0, 3, 2);

    // R3 divider handover
    cfg(BUF, 0, 3, 0);
    wait_pulse("R3", t1);
    wr(5, 2);
    rd(5, v); check("R3 psc preload readback", v, 2);
    wait_pulse("R3", t2); check("R3 old divider kept", t2 - t1, 4);
    wait_pulse("R3", t3); check("R3 new divider used", t3 - t2, 12);

    // R5 buffered period
    cfg(BUF, 0, 3, 0);
    wait_pulse("R5", t1);
    wr(6, 7);
    wait_pulse("R5", t2); check("R5 buffered old period", t2 - t1, 4);
    wait_pulse("R5", t3); check("R5 buffered new period", t3 - t2, 8);

    // R5 unbuffered, new period below count
    cfg(0, 0, 9, 0);
    wait_pulse("R5", t1);
    repeat (5) @(negedge clk);
    wr(6, 2);
    rd(4, v); check("R5 count above new period", v, 7);
    wait_pulse("R5", t2); check("R5 run to 0xFFFF", t2 - t1, 65536);
    wait_pulse("R5", t3); check("R5 immediate period", t3 - t2, 3);

    // R6 flag and interrupt
    cfg(BUF, 0, 2, 0);
    wait_pulse("R6", t1);
    check("R6 flag set", upd_flag, 1);
    check("R6 irq masked", irq, 0);
    wr(0, 0);
    repeat (10) @(negedge clk);
    rd(2, v); check("R6 flag sticky", v, 1);
    wr(1, 1); check("R6 irq enabled", irq, 1);
    wr(2, 1); check("R6 write one keeps flag", upd_flag, 1);
    wr(2, 0); check("R6 flag cleared", upd_flag, 0);
    check("R6 irq cleared", irq, 0);
    wr(1, 0);

    // R7 R12 forced update
    wr(4, 5); rd(4, v); check("R7 cnt written", v, 5);
    wr(5, 1); wr(6, 6); wr(7, 0);
    wr(3, 1);
    check("R12 pulse in load cycle", upd_pulse, 1);
    check("R12 flag in load cycle", upd_flag, 1);
    rd(4, v); check("R7 cnt cleared", v, 0);
    @(negedge clk); check("R12 pulse single cycle", upd_pulse, 0);
    wr(2, 0); wr(0, BUF | RUN);
    wait_pulse("R7", t1); wait_pulse("R7", t2);
    check("R7 shadows loaded", t2 - t1, 14);
    wr(0, BUF | DOWN); wr(6, 4); wr(3, 1);
    rd(4, v); check("R7 down force reloads", v, 4);

    // R11 hold
    cfg(BUF, 0, 100, 0);
    repeat (20) @(negedge clk);
    wr(0, BUF);
    rd(4, t1);
    repeat (10) @(negedge clk);
    rd(4, t2); check("R11 hold when stopped", t2, t1);
    tick_en = 0;
    wr(0, BUF | RUN);
    repeat (10) @(negedge clk);
    rd(4, t3); check("R11 hold when tick_en low", t3, t1);
    tick_en = 1;
    repeat (5) @(negedge clk);
    rd(4, v); check("R11 resumes", v, t1 + 5);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule